// File: doc/BRIEF.md
# Graphics Core Power and Reset Sequencer

This block steps a graphics core through three housekeeping sequences: a core reset, a power-down, and a wake-up from power-down. Software drives it through two 32-bit control/status registers. One sits in a general window and one in a privileged window. Both registers report the same 4-bit phase code, and software polls that code until a sequence is done.

A reset and a power-down each begin with a bus-isolation phase. During that phase the block raises `iso_req` and waits for `iso_ack`. A 16-bit phase counter moves the sequence on if the acknowledge never comes, so every sequence ends within a known number of cycles. The reset phase holds `core_rst` for a fixed number of cycles. While the core is powered down, `power_en` is low and `core_rst` is held.

The register port has no handshake. A write takes effect on the clock edge where `reg_wr` is high. Read data is a combinational function of `reg_addr` and the block state. The block carries no data stream, so every pin is a plain control or status level.

Top module: `gpu_pwr_seq`

## Requirements
- R1: The general window is at address 0x000 and the privileged window is at 0x400. Both read the phase code in bits 3:0: 0x0 idle, 0xA isolating before reset, 0xB resetting, 0xC isolating before power-down, 0xD powered down. Any other address reads 0, and a write to it has no effect.
- R2: In idle, a general-window write with bits 3:0 equal to 0x4 moves the block to 0xA on that edge, and `iso_req` goes high.
- R3: In 0xA or 0xC, a high `iso_ack` advances the phase on the next edge. With no acknowledge, the phase advances after exactly ISO_TIMEOUT cycles in the isolating state.
- R4: Phase 0xB keeps `core_rst` high for exactly RST_CYCLES cycles (16 by default) and then returns to idle.
- R5: In idle, a privileged-window write with bit 30 set enters 0xC. After isolation the block ends in 0xD, with `power_en` low and `core_rst` high.
- R6: In 0xD, a privileged-window write with bit 29 set returns the block to idle, with `power_en` high and `core_rst` low.
- R7: A command that does not fit the current phase has no effect on the phase. This covers a command that arrives while a sequence is running, bit 30 or bit 29 written through the general window, and a reset code other than 0x4.
- R8: Bits 30, 29 and 27 always read as 0. Bits 16:10 read as 0.
- R9: The interrupt flag (bit 31) sets on the edge where any sequence finishes. Writing 1 to bit 31 through either window clears it. If a clear arrives on the same edge as a finish, the flag stays set.
- R10: Through the privileged window, writing 1 to bit 28 sets the lock flag (read at bit 28) and writing 1 to bit 27 clears it. Bits 7:4 hold the value of the last privileged-window write. General-window writes change neither the lock flag nor bits 7:4.
- R11: A synchronous `rst` puts the block in idle with lock, interrupt and mode bits clear. Bits 9:8 report {`power_en`, not `core_rst`}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 11 | Register byte address |
| reg_wr | input | 1 | Write strobe, taken on the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| iso_ack | input | 1 | Bus isolation acknowledge |
| iso_req | output | 1 | Bus isolation request |
| core_rst | output | 1 | Core reset, active high |
| power_en | output | 1 | Core power enable |

## Verification
The completion of a sequence and a software clear of the interrupt flag can land on the same clock edge. The bench counts cycles from the moment the reset phase is entered. It then places a write of bit 31 on exactly the edge where the reset hold count runs out. After that edge it requires the phase to read idle and the flag to read set. A clear issued one cycle later must then clear the flag. A mismatch in either step means the set-over-clear ordering is wrong or the hold count is off by one.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE      = 4'h0,
    ST_ISO_RST   = 4'hA,
    ST_RESETTING = 4'hB,
    ST_ISO_OFF   = 4'hC,
    ST_OFF       = 4'hD
  } seq_state_e;

  localparam int unsigned REG_W      = 32;
  localparam int unsigned B_IRQ      = 31;
  localparam int unsigned B_PWR_DOWN = 30;
  localparam int unsigned B_PWR_UP   = 29;
  localparam int unsigned B_LOCK     = 28;
  localparam int unsigned B_UNLOCK   = 27;
  localparam logic [3:0]  RST_CODE   = 4'h4;

endpackage

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned ISO_TIMEOUT = 65535,
  parameter int unsigned RST_CYCLES  = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_rst,
  input  logic       cmd_off,
  input  logic       cmd_on,
  input  logic       iso_ack,
  output seq_state_e state,
  output logic       iso_req,
  output logic       core_rst,
  output logic       power_en,
  output logic       done
);

  localparam logic [CNT_W-1:0] ISO_LAST = CNT_W'(ISO_TIMEOUT - 1);
  localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RST_CYCLES - 1);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             iso_go;

  // one counter serves both as isolation watchdog and reset hold timer
  always_comb begin
    iso_go = iso_ack || (cnt_q == ISO_LAST);
    st_d   = st_q;
    cnt_d  = cnt_q + 1'b1;
    done   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (cmd_rst)      st_d = ST_ISO_RST;
        else if (cmd_off) st_d = ST_ISO_OFF;
      end
      ST_ISO_RST: if (iso_go) begin
        st_d  = ST_RESETTING;
        cnt_d = '0;
      end
      ST_RESETTING: if (cnt_q == RST_LAST) begin
        st_d  = ST_IDLE;
        cnt_d = '0;
        done  = 1'b1;
      end
      ST_ISO_OFF: if (iso_go) begin
        st_d  = ST_OFF;
        cnt_d = '0;
        done  = 1'b1;
      end
      ST_OFF: begin
        cnt_d = '0;
        if (cmd_on) begin
          st_d = ST_IDLE;
          done = 1'b1;
        end
      end
      default: begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state    = st_q;
  assign iso_req  = (st_q == ST_ISO_RST) || (st_q == ST_ISO_OFF);
  assign core_rst = (st_q == ST_RESETTING) || (st_q == ST_OFF);
  assign power_en = (st_q != ST_OFF);

  // R2: isolation before reset is entered only from idle
  p_iso_from_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ISO_RST && $past(st_q) != ST_ISO_RST) |-> $past(st_q) == ST_IDLE);

  // R3: acknowledge advances the isolating phases
  p_ack_advance_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ISO_RST && iso_ack) |=> st_q == ST_RESETTING);
  p_ack_off_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ISO_OFF && iso_ack) |=> st_q == ST_OFF);

  // R3: watchdog never overruns its limit while isolating
  p_wdog_bound_r3: assert property (@(posedge clk) disable iff (rst)
    iso_req |-> cnt_q < CNT_W'(ISO_TIMEOUT));

  // R4: reset hold never exceeds its count
  p_rst_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RESETTING) |-> cnt_q < CNT_W'(RST_CYCLES));

  // R5: powered-down state is reached only through its isolation phase
  p_off_entry_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_OFF && $past(st_q) != ST_OFF) |-> $past(st_q) == ST_ISO_OFF);

  // R6: wake command leaves powered-down state
  p_wake_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_OFF && cmd_on) |=> (st_q == ST_IDLE && power_en && !core_rst));

  // R7: a running reset sequence cannot be diverted to power-down
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ISO_RST) |=> (st_q == ST_ISO_RST || st_q == ST_RESETTING));

endmodule

// File: rtl/pwrseq_regif.sv
module pwrseq_regif
  import pwrseq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 11,
  parameter logic [ADDR_W-1:0] GEN_BASE  = 11'h000,
  parameter logic [ADDR_W-1:0] PRIV_BASE = 11'h400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  seq_state_e        state,
  input  logic              power_en,
  input  logic              core_rst,
  input  logic              done,
  output logic              cmd_rst,
  output logic              cmd_off,
  output logic              cmd_on
);

  logic       hit_gen, hit_priv, wr_gen, wr_priv, irq_clr;
  logic       irq_q, lock_q;
  logic [3:0] mode_q;

  assign hit_gen  = (reg_addr == GEN_BASE);
  assign hit_priv = (reg_addr == PRIV_BASE);
  assign wr_gen   = reg_wr && hit_gen;
  assign wr_priv  = reg_wr && hit_priv;

  // command pulses live for one cycle; the sequencer decides if they fit
  assign cmd_rst = wr_gen && (reg_wdata[3:0] == RST_CODE);
  assign cmd_off = wr_priv && reg_wdata[B_PWR_DOWN];
  assign cmd_on  = wr_priv && reg_wdata[B_PWR_UP];
  assign irq_clr = (wr_gen || wr_priv) && reg_wdata[B_IRQ];

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b0;
      lock_q <= 1'b0;
      mode_q <= '0;
    end else begin
      if (done)         irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
      if (wr_priv) begin
        if (reg_wdata[B_UNLOCK])    lock_q <= 1'b0;
        else if (reg_wdata[B_LOCK]) lock_q <= 1'b1;
        mode_q <= reg_wdata[7:4];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_gen || hit_priv) begin
      reg_rdata[B_IRQ]  = irq_q;
      reg_rdata[B_LOCK] = lock_q;
      reg_rdata[9]      = power_en;
      reg_rdata[8]      = !core_rst;
      reg_rdata[7:4]    = mode_q;
      reg_rdata[3:0]    = state;
    end
  end

  // R9: finishing a sequence always leaves the flag set
  p_irq_set_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> irq_q);

  // R9: a lone clear drops the flag
  p_irq_clr_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_clr && !done) |=> !irq_q);

  // R10: general-window writes leave lock and mode untouched
  p_gen_no_lock_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_gen && !wr_priv) |=> ($stable(lock_q) && $stable(mode_q)));

endmodule

// File: rtl/gpu_pwr_seq.sv
module gpu_pwr_seq
  import pwrseq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned ISO_TIMEOUT = 65535,
  parameter int unsigned RST_CYCLES  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              iso_ack,
  output logic              iso_req,
  output logic              core_rst,
  output logic              power_en
);

  seq_state_e state;
  logic       cmd_rst, cmd_off, cmd_on, done;

  pwrseq_regif #(
    .ADDR_W    (ADDR_W),
    .GEN_BASE  (ADDR_W'(11'h000)),
    .PRIV_BASE (ADDR_W'(11'h400))
  ) u_regif (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .state     (state),
    .power_en  (power_en),
    .core_rst  (core_rst),
    .done      (done),
    .cmd_rst   (cmd_rst),
    .cmd_off   (cmd_off),
    .cmd_on    (cmd_on)
  );

  pwrseq_fsm #(
    .CNT_W       (CNT_W),
    .ISO_TIMEOUT (ISO_TIMEOUT),
    .RST_CYCLES  (RST_CYCLES)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .cmd_rst  (cmd_rst),
    .cmd_off  (cmd_off),
    .cmd_on   (cmd_on),
    .iso_ack  (iso_ack),
    .state    (state),
    .iso_req  (iso_req),
    .core_rst (core_rst),
    .power_en (power_en),
    .done     (done)
  );

endmodule

// File: tb/gpu_pwr_seq_test.sv
module gpu_pwr_seq_test;

  localparam int unsigned TMO = 24;
  localparam int unsigned HOLD = 16;
  localparam logic [10:0] GEN = 11'h000;
  localparam logic [10:0] PRV = 11'h400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        iso_ack = 1'b0;
  logic        iso_req, core_rst, power_en;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  gpu_pwr_seq #(.ISO_TIMEOUT(TMO), .RST_CYCLES(HOLD)) uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .iso_ack(iso_ack),
    .iso_req(iso_req), .core_rst(core_rst), .power_en(power_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && core_rst; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(GEN, v); check("R11 reset readback", v, 32'h0000_0300);
    check("R11 outputs", {29'd0, iso_req, core_rst, power_en}, 32'd1);
    rd(11'h200, v); check("R1 unmapped read", v, 32'd0);
  endtask

  task automatic t_core_reset();
    logic [31:0] v;
    int n = 0;
    iso_ack = 1'b1;
    wr(GEN, 32'h4);
    rd(PRV, v); check("R2 phase A via privileged window", v[3:0], 32'hA);
    check("R2 iso_req", {31'd0, iso_req}, 32'd1);
    @(negedge clk);
    rd(GEN, v); check("R3 ack advance", v[3:0], 32'hB);
    while (core_rst && n < 100) begin n++; @(negedge clk); end
    check("R4 hold length", n, HOLD);
    rd(GEN, v); check("R4 back to idle", v[3:0], 32'h0);
    check("R9 irq set", v[31], 32'd1);
    wr(PRV, 32'h8000_0000);
    rd(GEN, v); check("R9 irq cleared", v[31], 32'd0);
    iso_ack = 1'b0;
  endtask

  task automatic t_watchdog();
    logic [31:0] v;
    int n = 0;
    wr(GEN, 32'h4);
    while (iso_req && n < 100) begin n++; @(negedge clk); end
    check("R3 watchdog length", n, TMO);
    rd(GEN, v); check("R3 watchdog to resetting", v[3:0], 32'hB);
    wait_idle();
    wr(GEN, 32'h8000_0000);
  endtask

  task automatic t_power();
    logic [31:0] v;
    wr(PRV, 32'h4000_0000);
    rd(PRV, v); check("R5 isolating for power-down", v[3:0], 32'hC);
    check("R8 command bits read zero", v & 32'h6801_FC00, 32'd0);
    iso_ack = 1'b1;
    @(negedge clk);
    iso_ack = 1'b0;
    rd(PRV, v); check("R5 powered down", v[3:0], 32'hD);
    check("R5 outputs", {30'd0, power_en, core_rst}, 32'd1);
    check("R11 status bits", v[9:8], 32'd0);
    wr(PRV, 32'h8000_0000);
    wr(GEN, 32'h4);
    wr(PRV, 32'h4000_0000);
    wr(GEN, 32'h2000_0000);
    rd(GEN, v); check("R7 commands ignored while down", v[3:0], 32'hD);
    wr(PRV, 32'h2000_0000);
    rd(GEN, v); check("R6 wake to idle", v[3:0], 32'h0);
    check("R6 outputs", {30'd0, power_en, core_rst}, 32'd2);
    check("R9 irq on wake", v[31], 32'd1);
    wr(GEN, 32'h8000_0000);
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    wr(PRV, 32'h2000_0000);
    rd(GEN, v); check("R7 wake in idle ignored", v, 32'h0000_0300);
    wr(GEN, 32'h5);
    wr(GEN, 32'h4000_0000);
    wr(11'h200, 32'h4);
    wr(11'h404, 32'h4000_0000);
    rd(GEN, v); check("R1 R7 stray writes ignored", v, 32'h0000_0300);
    wr(GEN, 32'h4);
    wr(PRV, 32'h4000_0000);
    rd(GEN, v); check("R7 busy command ignored", v[3:0], 32'hA);
    iso_ack = 1'b1;
    @(negedge clk);
    iso_ack = 1'b0;
    wait_idle();
    rd(GEN, v); check("R7 sequence completes as reset", v[3:0], 32'h0);
    wr(GEN, 32'h8000_0000);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    wr(PRV, 32'h1000_0000);
    rd(GEN, v); check("R10 lock set", v[28], 32'd1);
    wr(GEN, 32'h0800_0000);
    rd(GEN, v); check("R10 general unlock ignored", v[28], 32'd1);
    wr(PRV, 32'h0800_0000);
    rd(GEN, v); check("R10 lock cleared", v[28], 32'd0);
    wr(PRV, 32'h0000_00B0);
    wr(GEN, 32'h0000_0050);
    rd(GEN, v); check("R10 mode bits held", v[7:4], 32'hB);
    check("R8 reads", v & 32'h6801_FC00, 32'd0);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    iso_ack = 1'b1;
    wr(GEN, 32'h4);
    @(negedge clk);
    repeat (HOLD - 1) @(negedge clk);
    wr(GEN, 32'h8000_0000);
    iso_ack = 1'b0;
    rd(GEN, v); check("R9 set wins over clear", {v[31], 27'd0, v[3:0]}, 32'h8000_0000);
    wr(GEN, 32'h8000_0000);
    rd(GEN, v); check("R9 later clear", v[31], 32'd0);
  endtask

  task automatic t_block_reset();
    logic [31:0] v;
    wr(PRV, 32'h1000_0000);
    wr(GEN, 32'h4);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd(PRV, v); check("R11 mid-sequence reset", v, 32'h0000_0300);
    check("R11 iso_req low", {31'd0, iso_req}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_core_reset();
    t_watchdog();
    t_power();
    t_ignored();
    t_lock();
    t_collision();
    t_block_reset();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule